// File: doc/BRIEF.md
# Multi-Channel PWM Timer

This block produces pulse-width-modulated outputs on a parameterised number of channels (up to four). A single prescaler divides the input clock into counting ticks, and a single up-counter runs from zero to a reload value and wraps. Each channel compares the shared counter against its own compare value: the channel's reference is active while the counter is below that value. A per-channel polarity bit inverts the pin and a per-channel enable bit selects between the modulated waveform and the idle level.

Software drives the block through a flat register interface with write and read strobes. The prescaler is always applied at an update event. The reload value and each compare value can be double-buffered so that a new period or duty cycle starts cleanly at the next wrap. An update event happens either when the counter wraps or when software writes the event register. Enable and polarity bits of channels that are not built read back as zero, so software can find out how many channels exist.

Top module: `pwm_timer`

## Requirements
- R1: The counter advances once every (prescaler + 1) clock cycles. A value written to the prescaler register (address 5) takes effect only at the next update event.
- R2: The counter counts up from 0. At the tick where it has reached the active reload value it wraps to 0, so a period lasts (reload + 1) ticks. That wrap is an update event.
- R3: A channel's mode field is 8 bits, with bits [3:1] = 3'b110 selecting PWM mode 1. In that mode the reference is active while counter < active compare value, so a compare value of 0 gives 0 % duty and a compare value above the reload value gives 100 % duty. Any other mode code keeps the reference inactive.
- R4: The output configuration register (address 4) holds a 4-bit group per channel at bit offset 4×ch, with bit 0 = enable and bit 1 = polarity. Polarity 1 inverts the output. A disabled channel drives its inactive level, which equals its polarity bit.
- R5: Control bit 1 (address 0) enables reload preload. When it is set, a reload write (address 6) takes effect at the next update event. When it is clear, the write applies at once.
- R6: Mode field bit 0 enables compare preload for that channel. When it is set, a compare write takes effect at the next update event. When it is clear, the write applies at once.
- R7: Writing 1 to bit 0 of the event register (address 1) forces an update event: the preloaded values are loaded and the prescaler and counter are cleared. The event register reads as 0.
- R8: Control bit 0 starts counting. While it is clear, the counter holds its value.
- R9: Enable and polarity bits of channels at or above NUM_CH cannot be written and always read as 0.
- R10: Register map: 0 control, 1 event, 2 modes of ch0 [7:0] and ch1 [15:8], 3 modes of ch2 [7:0] and ch3 [15:8], 4 output configuration, 5 prescaler, 6 reload, 7 counter (read-only), 8+ch compare of channel ch. Every register resets to 0. rdata is 0 when rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; read data is combinational |
| addr | input | ADDR_W | Register word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, 0 when rd_en is low |
| pwm_o | output | NUM_CH | Channel outputs |

## Verification
The assertions check these properties on every cycle:
- the prescaler phase never exceeds the active divide value;
- a forced update clears the counter;
- a stopped counter holds;
- a preloaded compare value stays put between updates;
- a zero compare value or a disabled channel drives the polarity level;
- the event register and the unimplemented configuration bits read as 0.

Only the bench scenarios can show the rest:
- duty cycles and periods measured over a whole period for many prescaler, reload, compare and polarity mixes;
- the deferral of reload and prescaler changes until the next wrap, against their immediate effect;
- the exact cycle at which counting resumes after a forced update.

// File: rtl/pwm_timer_pkg.sv
// Package: shared register addresses and mode codes of the PWM timer.
// Assumes an address bus of at least 4 bits.
package pwm_timer_pkg;
    localparam int MAX_CH     = 4;
    localparam int RA_CTRL    = 0;
    localparam int RA_EVENT   = 1;
    localparam int RA_MODE_A  = 2;
    localparam int RA_MODE_B  = 3;
    localparam int RA_OUTCFG  = 4;
    localparam int RA_PSC     = 5;
    localparam int RA_RELOAD  = 6;
    localparam int RA_COUNT   = 7;
    localparam int RA_CMP0    = 8;
    localparam logic [2:0] MODE_PWM1 = 3'b110;
endpackage

// File: rtl/pwm_regfile.sv
// Module: register file of the PWM timer. It holds the control, mode,
// output-configuration, prescaler, reload and compare registers, decodes
// writes, produces the forced-update pulse and muxes read data.
// Assumes single-cycle write strobes and a combinational read path.
module pwm_regfile
    import pwm_timer_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         rd_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [CNT_W-1:0]             cnt_i,
    output logic                         run_o,
    output logic                         rld_pre_o,
    output logic                         ug_o,
    output logic [PSC_W-1:0]             psc_o,
    output logic [CNT_W-1:0]             arr_o,
    output logic                         arr_we_o,
    output logic [CNT_W-1:0]             wval_o,
    output logic [NUM_CH-1:0][3:0]       mode_o,
    output logic [NUM_CH-1:0]            en_o,
    output logic [NUM_CH-1:0]            pol_o,
    output logic [NUM_CH-1:0][CNT_W-1:0] cmp_o,
    output logic [NUM_CH-1:0]            cmp_we_o,
    output logic [DATA_W-1:0]            rdata_o
);
    logic [1:0]                  ctrl_q;
    logic [PSC_W-1:0]            psc_q;
    logic [CNT_W-1:0]            arr_q;
    logic [NUM_CH-1:0][7:0]      mode_q;
    logic [NUM_CH-1:0]           en_q;
    logic [NUM_CH-1:0]           pol_q;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_q;

    // Shared registers: control, prescaler, reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            psc_q  <= '0;
            arr_q  <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(RA_CTRL))   ctrl_q <= wdata[1:0];
            if (addr == ADDR_W'(RA_PSC))    psc_q  <= wdata[PSC_W-1:0];
            if (addr == ADDR_W'(RA_RELOAD)) arr_q  <= wdata[CNT_W-1:0];
        end
    end

    // Per-channel registers, built only for implemented channels.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam int MADDR = (ch < 2) ? RA_MODE_A : RA_MODE_B;
        localparam int MOFF  = 8 * (ch % 2);
        logic hit_mode, hit_cfg, hit_cmp;
        assign hit_mode = wr_en && (addr == ADDR_W'(MADDR));
        assign hit_cfg  = wr_en && (addr == ADDR_W'(RA_OUTCFG));
        assign hit_cmp  = wr_en && (addr == ADDR_W'(RA_CMP0 + ch));

        // Store the mode field, enable/polarity pair and compare value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_q[ch] <= '0;
                en_q[ch]   <= 1'b0;
                pol_q[ch]  <= 1'b0;
                cmp_q[ch]  <= '0;
            end else begin
                if (hit_mode) mode_q[ch] <= wdata[MOFF +: 8];
                if (hit_cfg) begin
                    en_q[ch]  <= wdata[4*ch];
                    pol_q[ch] <= wdata[4*ch+1];
                end
                if (hit_cmp) cmp_q[ch] <= wdata[CNT_W-1:0];
            end
        end

        assign mode_o[ch]   = mode_q[ch][3:0];
        assign cmp_we_o[ch] = hit_cmp;
    end

    assign run_o     = ctrl_q[0];
    assign rld_pre_o = ctrl_q[1];
    assign ug_o      = wr_en && (addr == ADDR_W'(RA_EVENT)) && wdata[0];
    assign psc_o     = psc_q;
    assign arr_o     = arr_q;
    assign arr_we_o  = wr_en && (addr == ADDR_W'(RA_RELOAD));
    assign wval_o    = wdata[CNT_W-1:0];
    assign en_o      = en_q;
    assign pol_o     = pol_q;
    assign cmp_o     = cmp_q;

    // Read multiplexer; unimplemented fields stay zero.
    always_comb begin
        rdata_o = '0;
        if (rd_en) begin
            if (addr == ADDR_W'(RA_CTRL))   rdata_o[1:0]       = ctrl_q;
            if (addr == ADDR_W'(RA_PSC))    rdata_o[PSC_W-1:0] = psc_q;
            if (addr == ADDR_W'(RA_RELOAD)) rdata_o[CNT_W-1:0] = arr_q;
            if (addr == ADDR_W'(RA_COUNT))  rdata_o[CNT_W-1:0] = cnt_i;
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (addr == ADDR_W'((ch < 2) ? RA_MODE_A : RA_MODE_B))
                    rdata_o[8*(ch%2) +: 8] = mode_q[ch];
                if (addr == ADDR_W'(RA_OUTCFG)) begin
                    rdata_o[4*ch]   = en_q[ch];
                    rdata_o[4*ch+1] = pol_q[ch];
                end
                if (addr == ADDR_W'(RA_CMP0 + ch))
                    rdata_o[CNT_W-1:0] = cmp_q[ch];
            end
        end
    end

    // R7: the event register never reads back a set bit.
    a_r7_event_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(RA_EVENT)) |-> (rdata_o == '0));

    if (NUM_CH < MAX_CH) begin : g_unimpl_chk
        // R9: groups of absent channels read as zero.
        a_r9_absent_groups_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && addr == ADDR_W'(RA_OUTCFG)) |-> (rdata_o[4*MAX_CH-1:4*NUM_CH] == '0));
    end
endmodule

// File: rtl/pwm_prescaler.sv
// Module: clock prescaler. It emits a one-cycle counting tick every
// (divide value + 1) cycles while running. The divide value is taken
// from the programmed register only at an update event.
// Assumes upd covers both forced updates and counter wraps.
module pwm_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ug,
    input  logic             upd,
    input  logic [PSC_W-1:0] psc_i,
    output logic             tick_o
);
    logic [PSC_W-1:0] psc_act;
    logic [PSC_W-1:0] pcnt;

    // Shadow divide value, loaded on every update event.
    always_ff @(posedge clk) begin
        if (!rst_n)   psc_act <= '0;
        else if (upd) psc_act <= psc_i;
    end

    // Phase counter: cleared by a forced update, wraps at the divide value.
    always_ff @(posedge clk) begin
        if (!rst_n)   pcnt <= '0;
        else if (ug)  pcnt <= '0;
        else if (run) pcnt <= (pcnt == psc_act) ? '0 : pcnt + 1'b1;
    end

    assign tick_o = run && (pcnt == psc_act);

    // R1: the phase never passes the active divide value.
    a_r1_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= psc_act);
endmodule

// File: rtl/pwm_counter.sv
// Module: shared up-counter with a double-buffered reload value.
// It wraps after reaching the active reload value and flags update events.
// Assumes tick is a one-cycle enable from the prescaler.
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ug,
    input  logic             rld_pre,
    input  logic             arr_we,
    input  logic [CNT_W-1:0] wval,
    input  logic [CNT_W-1:0] arr_q,
    output logic [CNT_W-1:0] cnt_o,
    output logic             upd_o
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] arr_act;
    logic             wrap;

    assign wrap  = tick && (cnt >= arr_act);
    assign upd_o = ug || wrap;
    assign cnt_o = cnt;

    // Count on each tick, clear on wrap or forced update.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (ug)   cnt <= '0;
        else if (tick) cnt <= wrap ? '0 : cnt + 1'b1;
    end

    // Active reload: direct write without preload, else loaded at update.
    always_ff @(posedge clk) begin
        if (!rst_n)                 arr_act <= '0;
        else if (arr_we && !rld_pre) arr_act <= wval;
        else if (upd_o)             arr_act <= arr_q;
    end

    // R7: a forced update leaves the counter at zero.
    a_r7_force_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ug |=> (cnt == '0));

    // R2: below the reload value a tick advances the count by one.
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ug && cnt < arr_act) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/pwm_channel.sv
// Module: one PWM channel. It holds the compare shadow, forms the PWM
// mode 1 reference and applies enable and polarity.
// Assumes mode_i[0] is compare preload and mode_i[3:1] the mode code.
module pwm_channel
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [CNT_W-1:0] cnt,
    input  logic [3:0]       mode_i,
    input  logic             en,
    input  logic             pol,
    input  logic [CNT_W-1:0] cmp_q,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] wval,
    output logic             out_o
);
    logic [CNT_W-1:0] cmp_act;
    logic             pre, pwm1, refsig;

    assign pre  = mode_i[0];
    assign pwm1 = (mode_i[3:1] == MODE_PWM1);

    // Active compare: direct write without preload, else loaded at update.
    always_ff @(posedge clk) begin
        if (!rst_n)              cmp_act <= '0;
        else if (cmp_we && !pre) cmp_act <= wval;
        else if (upd)            cmp_act <= cmp_q;
    end

    assign refsig = pwm1 && (cnt < cmp_act);
    assign out_o  = en ? (refsig ^ pol) : pol;

    // R6: with preload set the compare holds until an update event.
    a_r6_preload_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pre && !upd) |=> $stable(cmp_act));

    // R3: a zero compare never activates the output.
    a_r3_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_act == '0) |-> (out_o == pol));

    // R4: a disabled channel sits at its polarity level.
    a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (out_o == pol));
endmodule

// File: rtl/pwm_timer.sv
// Module: top of the multi-channel PWM timer. It connects the register
// file, the shared prescaler and counter, and one channel per output.
// Assumes NUM_CH between 1 and 4 and DATA_W >= 16.
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] pwm_o
);
    logic                         run, rld_pre, ug, arr_we, tick, upd;
    logic [PSC_W-1:0]             psc_q;
    logic [CNT_W-1:0]             arr_q, wval, cnt;
    logic [NUM_CH-1:0][3:0]       mode;
    logic [NUM_CH-1:0]            en, pol, cmp_we;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_q;

    pwm_regfile #(
        .NUM_CH(NUM_CH), .CNT_W(CNT_W), .PSC_W(PSC_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .cnt_i(cnt),
        .run_o(run), .rld_pre_o(rld_pre), .ug_o(ug),
        .psc_o(psc_q), .arr_o(arr_q), .arr_we_o(arr_we), .wval_o(wval),
        .mode_o(mode), .en_o(en), .pol_o(pol),
        .cmp_o(cmp_q), .cmp_we_o(cmp_we), .rdata_o(rdata)
    );

    pwm_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .run(run), .ug(ug), .upd(upd),
        .psc_i(psc_q), .tick_o(tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ug(ug), .rld_pre(rld_pre),
        .arr_we(arr_we), .wval(wval), .arr_q(arr_q),
        .cnt_o(cnt), .upd_o(upd)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        pwm_channel #(.CNT_W(CNT_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .upd(upd), .cnt(cnt),
            .mode_i(mode[ch]), .en(en[ch]), .pol(pol[ch]),
            .cmp_q(cmp_q[ch]), .cmp_we(cmp_we[ch]), .wval(wval),
            .out_o(pwm_o[ch])
        );
    end

    // R8: a stopped counter holds unless software forces an update.
    a_r8_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ug) |=> $stable(cnt));
endmodule

// File: tb/pwm_timer_tb_top.sv
module pwm_timer_tb_top;
    localparam int NCH = 3;
    localparam int AW  = 4;
    localparam int DW  = 16;
    localparam int A_CTRL = 0, A_EVT = 1, A_MA = 2, A_MB = 3, A_CFG = 4;
    localparam int A_PSC = 5, A_RLD = 6, A_CNT = 7, A_CMP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [NCH-1:0] pwm_o;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pwm_timer #(.NUM_CH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        addr  = a[AW-1:0];
        wdata = d[DW-1:0];
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        addr  = a[AW-1:0];
        rd_en = 1'b1;
        #1;
        d     = int'(rdata);
        rd_en = 1'b0;
    endtask

    function automatic int exp_high(int p, int a, int c, bit pol);
        int n = (p + 1) * (a + 1);
        int h = (p + 1) * ((c < a + 1) ? c : a + 1);
        return pol ? n - h : h;
    endfunction

    // R1 R2 R3 R4: configure one channel, then count active cycles over a period.
    task automatic duty_run(input int ch, input int p, input int a, input int c,
                            input bit pol, input bit pre, input string req);
        int hi = 0;
        int n = (p + 1) * (a + 1);
        wr(A_CTRL, 0);
        wr(A_PSC, p);
        wr(A_RLD, a);
        wr((ch < 2) ? A_MA : A_MB, (8'h0C | int'(pre)) << (8 * (ch % 2)));
        wr(A_CMP + ch, c);
        wr(A_CFG, (1 | (int'(pol) << 1)) << (4 * ch));
        wr(A_EVT, 1);
        wr(A_CTRL, 1);
        repeat (n) begin
            @(negedge clk);
            if (pwm_o[ch]) hi++;
        end
        chk(req, hi, exp_high(p, a, c, pol));
    endtask

    initial begin
        int v, v2, mx, expv;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset values and idle outputs.
        rd(A_CTRL, v); chk("R10 ctrl reset", v, 0);
        rd(A_PSC, v);  chk("R10 psc reset", v, 0);
        rd(A_RLD, v);  chk("R10 reload reset", v, 0);
        rd(A_CNT, v);  chk("R10 count reset", v, 0);
        rd(A_CFG, v);  chk("R10 outcfg reset", v, 0);
        chk("R10 outputs reset", int'(pwm_o), 0);

        // R9: absent channel groups cannot be set.
        wr(A_CFG, 16'hFFFF);
        expv = 0;
        for (int ch = 0; ch < NCH; ch++) expv |= 3 << (4 * ch);
        rd(A_CFG, v); chk("R9 absent groups read zero", v, expv);
        wr(A_CFG, 0);

        // R7: event register reads zero.
        rd(A_EVT, v); chk("R7 event reads zero", v, 0);

        // R4: disabled channel with polarity 1 drives high.
        wr(A_CFG, 16'h0020);
        chk("R4 disabled pol1 level", int'(pwm_o[1]), 1);
        chk("R4 disabled pol0 level", int'(pwm_o[0]), 0);

        // R6: compare preload on a stopped counter.
        wr(A_CTRL, 0); wr(A_PSC, 0); wr(A_RLD, 9);
        wr(A_MA, 16'h000D); wr(A_CMP, 0); wr(A_CFG, 1); wr(A_EVT, 1);
        chk("R6 cmp zero start", int'(pwm_o[0]), 0);
        wr(A_CMP, 5);
        chk("R6 preloaded cmp not yet active", int'(pwm_o[0]), 0);
        rd(A_CMP, v); chk("R10 cmp readback", v, 5);
        wr(A_EVT, 1);
        chk("R6 cmp active after update", int'(pwm_o[0]), 1);
        wr(A_MA, 16'h000C); wr(A_CMP, 0);
        chk("R6 immediate cmp without preload", int'(pwm_o[0]), 0);

        // R3: non-PWM mode code keeps the reference inactive.
        wr(A_MA, 16'h0000); wr(A_CMP, 5);
        chk("R3 other mode inactive", int'(pwm_o[0]), 0);

        // R7 R1: forced update clears prescaler phase and counter.
        wr(A_PSC, 3); wr(A_RLD, 9); wr(A_EVT, 1); wr(A_CTRL, 1);
        repeat (6) @(negedge clk);
        wr(A_EVT, 1);
        rd(A_CNT, v); chk("R7 count cleared by event", v, 0);
        repeat (3) @(negedge clk);
        rd(A_CNT, v); chk("R1 count held three cycles", v, 0);
        @(negedge clk);
        rd(A_CNT, v); chk("R1 first step after four cycles", v, 1);

        // R1: a new prescaler waits for the next update.
        wr(A_CTRL, 0); wr(A_PSC, 3); wr(A_EVT, 1); wr(A_PSC, 0); wr(A_CTRL, 1);
        repeat (8) @(negedge clk);
        rd(A_CNT, v); chk("R1 prescaler deferred", v, 2);

        // R8: stopped counter holds.
        wr(A_CTRL, 0);
        rd(A_CNT, v);
        repeat (10) @(negedge clk);
        rd(A_CNT, v2); chk("R8 count holds when stopped", v2, v);

        // R5: reload preload defers the new period.
        wr(A_PSC, 0); wr(A_RLD, 9); wr(A_EVT, 1); wr(A_CTRL, 3);
        wr(A_RLD, 2);
        mx = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            rd(A_CNT, v);
            if (v == 0) break;
            if (v > mx) mx = v;
        end
        chk("R5 old period completes", mx, 9);
        mx = 0;
        repeat (6) begin
            @(negedge clk);
            rd(A_CNT, v);
            if (v > mx) mx = v;
        end
        chk("R5 new period after update", mx, 2);

        // R5: without preload the reload applies at once.
        wr(A_CTRL, 0); wr(A_RLD, 9); wr(A_EVT, 1); wr(A_CTRL, 1);
        repeat (5) @(negedge clk);
        wr(A_RLD, 2);
        repeat (3) @(negedge clk);
        mx = 0;
        repeat (9) begin
            @(negedge clk);
            rd(A_CNT, v);
            if (v > mx) mx = v;
        end
        chk("R5 immediate reload", mx, 2);

        // R3 R2 R4: directed duty corners.
        duty_run(0, 1, 4, 7, 1'b0, 1'b1, "R3 compare above reload full duty");
        duty_run(1, 2, 5, 0, 1'b0, 1'b0, "R3 compare zero no duty");
        duty_run(2, 0, 7, 3, 1'b1, 1'b1, "R4 polarity inverts duty");
        duty_run(0, 0, 0, 1, 1'b0, 1'b0, "R2 reload zero one-tick period");

        // R1 R2 R3 R4: random mixes.
        for (int i = 0; i < 16; i++) begin
            int ch = int'($urandom_range(NCH - 1, 0));
            int p  = int'($urandom_range(3, 0));
            int a  = int'($urandom_range(15, 0));
            int c  = int'($urandom_range(20, 0));
            bit pl = 1'($urandom_range(1, 0));
            bit pr = 1'($urandom_range(1, 0));
            duty_run(ch, p, a, c, pl, pr, "R2 R3 random duty");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule